// File: doc/BRIEF.md
# Permission-Tracked Set-Associative Tag Directory

This block is the tag and state side of a set-associative cache. It keeps no data. For every way of every set it holds an occupancy flag, the full line address, a permission state and a lock owner. A caller presents line-aligned addresses on a request stream that offers four operations: access, allocate, deallocate and victim probe. Each accepted request returns one registered response. The response gives the matching way, whether the access is permitted for its kind, whether the set has a slot for the address, the address of the replacement victim, and whether an allocation was refused.

Two plain side ports change state outside the request stream. The state port writes a new permission into every occupied way whose address matches. The lock port sets, clears or tests an owner context on a present line. A tag match by itself is not a hit: a line in the absent state counts as a miss and is reusable as a free slot. The permission state and the access kind together decide whether an access is granted. Recency is tracked by a saturating age per way.

Back-pressure works as follows. `req_ready` is high whenever no response is waiting, or the waiting response is being taken in the same cycle (`rsp_ready` high). A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears after that edge with `rsp_valid` high. The response stays unchanged until a cycle where `rsp_ready` is high.

Top module: `tagdir`

## Requirements
- R1: The set of an address is the field `addr[IDX_LSB +: log2(SETS)]`, where SETS = CAP_BYTES / WAYS / LINE_BYTES. The defaults give 4 sets at bits [5:4]. Addresses that differ only above that field compete for the same ways. Addresses that differ in it never compete.
- R2: An access reports a hit only when an occupied way holds the same address and its state is not absent. The state codes are absent = 0, invalid = 1, read-only = 2, read-write = 3, busy = 4. `rsp_way` reports the lowest-numbered hitting way.
- R3: An access is granted when the hit line is read-write, for any kind. On a read-only line it is granted only for kind load (0) or fetch (1), and not for store (2). Invalid and busy lines are never granted, but the hit and the way are still reported.
- R4: Every access that hits makes its way the most recent, including accesses that are denied.
- R5: `rsp_avail` is high when an occupied way already holds the address (in any state), or when some way of the set is unoccupied or absent.
- R6: Allocate writes into the lowest-numbered way that is unoccupied or absent. The new line is in the invalid state with no lock owner. It becomes the most recent only when `req_touch` is high. `rsp_way` reports the way written.
- R7: Deallocate of a hitting address leaves that way unoccupied. Later accesses to the address miss.
- R8: Each way has an age. At reset every age is WAYS-1. When a way becomes the most recent its age is set to 0, and every other way of the set increments its age, saturating at WAYS-1. The probe victim is the way with the largest age, ties going to the lowest index. `rsp_victim` is that way's address whenever `rsp_avail` is low.
- R9: Lock operations are coded as 0 = set owner to `lk_ctx`, 1 = clear owner, 2 = test. They act only on a hitting line. `lk_found` shows a hit in the same cycle. `lk_match` is high only for a test whose context equals the stored owner.
- R10: Allocating an address that already hits, or allocating when `rsp_avail` would be low, sets `rsp_err` and the sticky `alloc_err`. The directory is left unchanged.
- R11: The request and response streams follow the valid/ready rules described above. The response comes out one cycle after acceptance and is held while stalled.
- R12: After reset every way is unoccupied, `rsp_valid` and `alloc_err` are low, and `req_ready` is high.
- R13: A write on the state port sets the state of every occupied way whose address matches, in whatever state that way was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 access, 1 allocate, 2 deallocate, 3 probe |
| req_addr | input | ADDR_W | Line address |
| req_kind | input | 2 | Access kind: 0 load, 1 fetch, 2 store |
| req_touch | input | 1 | Allocate also makes the way most recent |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Address hit (non-absent match) |
| rsp_way | output | log2(WAYS) | Hit way, or way allocated |
| rsp_grant | output | 1 | Access permitted |
| rsp_avail | output | 1 | Slot available for the address |
| rsp_err | output | 1 | Allocation refused |
| rsp_victim | output | ADDR_W | Address held by the victim way |
| alloc_err | output | 1 | Sticky allocation error |
| pw_en | input | 1 | State write strobe |
| pw_addr | input | ADDR_W | State write address |
| pw_state | input | 3 | New state code |
| lk_en | input | 1 | Lock operation strobe |
| lk_op | input | 2 | 0 set, 1 clear, 2 test |
| lk_addr | input | ADDR_W | Lock address |
| lk_ctx | input | CTX_W | Owner context |
| lk_found | output | 1 | Lock address hits |
| lk_match | output | 1 | Test result |

## Verification
Directed sequences step one line through every permission state under each access kind. This separates a tag match from a grant, and shows whether a denied store still refreshes recency. One set is filled with same-index addresses, and one further address of the same index is added. This separates "slot available" from "address already held". It also drives the refused allocation, the victim order under age ties, and the reuse of an absent way ahead of higher empty ways. A stalled response with a second request waiting shows whether back-pressure holds the first result and delays the second. A long seeded random mix over a 32-address pool, with state writes that include the absent state, compares every response field with a bench model. This exposes disagreement in way choice, saturating ages and lock ownership that the directed cases do not reach.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [2:0] {
    PERM_ABSENT  = 3'd0,
    PERM_INVALID = 3'd1,
    PERM_RDONLY  = 3'd2,
    PERM_RDWR    = 3'd3,
    PERM_BUSY    = 3'd4
  } perm_e;

  typedef enum logic [1:0] {
    OP_ACCESS  = 2'd0,
    OP_ALLOC   = 2'd1,
    OP_DEALLOC = 2'd2,
    OP_PROBE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    LK_SET   = 2'd0,
    LK_CLEAR = 2'd1,
    LK_TEST  = 2'd2
  } lkop_e;
endpackage

// File: rtl/tagdir_first.sv
module tagdir_first #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tagdir_setmatch.sv
module tagdir_setmatch #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WW    = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0]            key,
  input  logic [WAYS-1:0]              occ,
  input  logic [WAYS-1:0]              absent,
  input  logic [WAYS-1:0][ADDR_W-1:0]  line,
  output logic [WAYS-1:0]              tag_vec,
  output logic                         hit_any,
  output logic [WW-1:0]                hit_way,
  output logic                         free_any,
  output logic [WW-1:0]                free_way,
  output logic                         avail
);
  logic [WAYS-1:0] hit_vec, free_vec;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tag_vec[w]  = occ[w] && (line[w] == key);
      hit_vec[w]  = tag_vec[w] && !absent[w];
      free_vec[w] = !occ[w] || absent[w];
    end
  end

  tagdir_first #(.N(WAYS)) u_hit  (.vec(hit_vec),  .any(hit_any),  .idx(hit_way));
  tagdir_first #(.N(WAYS)) u_free (.vec(free_vec), .any(free_any), .idx(free_way));

  assign avail = (|tag_vec) || free_any;
endmodule

// File: rtl/tagdir_age.sv
module tagdir_age #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  localparam int SW   = $clog2(SETS),
  localparam int WW   = $clog2(WAYS),
  localparam int OLD  = WAYS - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [SW-1:0] touch_set,
  input  logic [WW-1:0] touch_way,
  input  logic [SW-1:0] rd_set,
  output logic [WW-1:0] victim_way
);
  logic [WW-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WW'(OLD);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] != WW'(OLD))
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  // oldest way wins, lowest index on equal age
  always_comb begin
    victim_way = '0;
    for (int w = 1; w < WAYS; w++)
      if (age_q[rd_set][w] > age_q[rd_set][victim_way])
        victim_way = WW'(w);
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_chk
    assert_victim_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q[rd_set][g] <= age_q[rd_set][victim_way]) &&
      ((g >= int'(victim_way)) || (age_q[rd_set][g] != age_q[rd_set][victim_way])));
  end

  assert_touched_newest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en && (touch_set == rd_set) |=> $past(rst_n) |-> (age_q[$past(touch_set)][$past(touch_way)] == '0));
endmodule

// File: rtl/tagdir.sv
module tagdir
  import tagdir_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CAP_BYTES  = 256,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int IDX_LSB    = $clog2(LINE_BYTES),
  parameter int CTX_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_kind,
  input  logic                     req_touch,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_hit,
  output logic [$clog2(WAYS)-1:0]  rsp_way,
  output logic                     rsp_grant,
  output logic                     rsp_avail,
  output logic                     rsp_err,
  output logic [ADDR_W-1:0]        rsp_victim,
  output logic                     alloc_err,
  input  logic                     pw_en,
  input  logic [ADDR_W-1:0]        pw_addr,
  input  logic [2:0]               pw_state,
  input  logic                     lk_en,
  input  logic [1:0]               lk_op,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [CTX_W-1:0]         lk_ctx,
  output logic                     lk_found,
  output logic                     lk_match
);
  localparam int SETS  = CAP_BYTES / WAYS / LINE_BYTES;
  localparam int SW    = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int NLOOK = 3;          // 0 request, 1 state port, 2 lock port
  localparam int CH_REQ = 0, CH_PW = 1, CH_LK = 2;

  // directory storage
  logic              occ_q  [SETS][WAYS];
  logic [ADDR_W-1:0] line_q [SETS][WAYS];
  perm_e             perm_q [SETS][WAYS];
  logic              lkv_q  [SETS][WAYS];
  logic [CTX_W-1:0]  own_q  [SETS][WAYS];

  // parallel lookups
  logic [ADDR_W-1:0] key      [NLOOK];
  logic [SW-1:0]     kset     [NLOOK];
  logic [WAYS-1:0]   m_tag    [NLOOK];
  logic              m_hit    [NLOOK];
  logic [WW-1:0]     m_hway   [NLOOK];
  logic              m_free   [NLOOK];
  logic [WW-1:0]     m_fway   [NLOOK];
  logic              m_avail  [NLOOK];

  assign key[CH_REQ] = req_addr;
  assign key[CH_PW]  = pw_addr;
  assign key[CH_LK]  = lk_addr;

  for (genvar c = 0; c < NLOOK; c++) begin : g_look
    logic [WAYS-1:0]             occ_v, abs_v;
    logic [WAYS-1:0][ADDR_W-1:0] line_v;
    assign kset[c] = key[c][IDX_LSB +: SW];
    always_comb begin
      for (int w = 0; w < WAYS; w++) begin
        occ_v[w]  = occ_q[kset[c]][w];
        abs_v[w]  = (perm_q[kset[c]][w] == PERM_ABSENT);
        line_v[w] = line_q[kset[c]][w];
      end
    end
    tagdir_setmatch #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
      .key(key[c]), .occ(occ_v), .absent(abs_v), .line(line_v),
      .tag_vec(m_tag[c]), .hit_any(m_hit[c]), .hit_way(m_hway[c]),
      .free_any(m_free[c]), .free_way(m_fway[c]), .avail(m_avail[c]));
  end

  // request decode
  logic    accept, is_acc, is_alloc, is_dealloc, alloc_bad, alloc_ok, grant;
  logic    touch_en;
  logic [WW-1:0] touch_way, vic_way;
  perm_e   hperm;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign accept     = req_valid && req_ready;
  assign is_acc     = (req_op == OP_ACCESS);
  assign is_alloc   = (req_op == OP_ALLOC);
  assign is_dealloc = (req_op == OP_DEALLOC);
  assign hperm      = perm_q[kset[CH_REQ]][m_hway[CH_REQ]];
  assign alloc_bad  = m_hit[CH_REQ] || !m_avail[CH_REQ];
  assign alloc_ok   = accept && is_alloc && !alloc_bad;
  assign grant      = m_hit[CH_REQ] &&
                      ((hperm == PERM_RDWR) ||
                       ((hperm == PERM_RDONLY) && (req_kind != KIND_STORE)));
  assign touch_en   = accept && ((is_acc && m_hit[CH_REQ]) || (is_alloc && !alloc_bad && req_touch));
  assign touch_way  = is_alloc ? m_fway[CH_REQ] : m_hway[CH_REQ];

  tagdir_age #(.SETS(SETS), .WAYS(WAYS)) u_age (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(kset[CH_REQ]),
    .touch_way(touch_way), .rd_set(kset[CH_REQ]), .victim_way(vic_way));

  // lock port
  logic [CTX_W-1:0] lk_own;
  logic             lk_own_v;
  assign lk_own   = own_q[kset[CH_LK]][m_hway[CH_LK]];
  assign lk_own_v = lkv_q[kset[CH_LK]][m_hway[CH_LK]];
  assign lk_found = m_hit[CH_LK];
  assign lk_match = lk_en && (lk_op == LK_TEST) && m_hit[CH_LK] && lk_own_v && (lk_own == lk_ctx);

  // storage update: state port, then lock port, then request (last wins)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          occ_q[s][w]  <= 1'b0;
          line_q[s][w] <= '0;
          perm_q[s][w] <= PERM_ABSENT;
          lkv_q[s][w]  <= 1'b0;
          own_q[s][w]  <= '0;
        end
    end else begin
      if (pw_en)
        for (int w = 0; w < WAYS; w++)
          if (m_tag[CH_PW][w]) perm_q[kset[CH_PW]][w] <= perm_e'(pw_state);
      if (lk_en && m_hit[CH_LK]) begin
        if (lk_op == LK_SET) begin
          lkv_q[kset[CH_LK]][m_hway[CH_LK]] <= 1'b1;
          own_q[kset[CH_LK]][m_hway[CH_LK]] <= lk_ctx;
        end else if (lk_op == LK_CLEAR) begin
          lkv_q[kset[CH_LK]][m_hway[CH_LK]] <= 1'b0;
        end
      end
      if (alloc_ok) begin
        occ_q[kset[CH_REQ]][m_fway[CH_REQ]]  <= 1'b1;
        line_q[kset[CH_REQ]][m_fway[CH_REQ]] <= req_addr;
        perm_q[kset[CH_REQ]][m_fway[CH_REQ]] <= PERM_INVALID;
        lkv_q[kset[CH_REQ]][m_fway[CH_REQ]]  <= 1'b0;
      end
      if (accept && is_dealloc && m_hit[CH_REQ]) begin
        occ_q[kset[CH_REQ]][m_hway[CH_REQ]]  <= 1'b0;
        perm_q[kset[CH_REQ]][m_hway[CH_REQ]] <= PERM_ABSENT;
        lkv_q[kset[CH_REQ]][m_hway[CH_REQ]]  <= 1'b0;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_grant  <= 1'b0;
      rsp_avail  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_victim <= '0;
      alloc_err  <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid  <= 1'b1;
        rsp_hit    <= m_hit[CH_REQ];
        rsp_way    <= is_alloc ? m_fway[CH_REQ] : m_hway[CH_REQ];
        rsp_grant  <= is_acc && grant;
        rsp_avail  <= m_avail[CH_REQ];
        rsp_err    <= is_alloc && alloc_bad;
        rsp_victim <= line_q[kset[CH_REQ]][vic_way];
        if (is_alloc && alloc_bad) alloc_err <= 1'b1;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_way) && $stable(rsp_victim) &&
                                $stable(rsp_grant) && $stable(rsp_hit));
  assert_grant_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_grant |-> rsp_hit);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err);
  assert_err_raises_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> alloc_err);
endmodule

// File: tb/tagdir_test.sv
module tagdir_test;
  localparam int AW = 16, W = 4, S = 4, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1, req_touch = 0;
  logic [1:0] req_op = 0, req_kind = 0, lk_op = 0;
  logic [AW-1:0] req_addr = 0, pw_addr = 0, lk_addr = 0;
  logic pw_en = 0, lk_en = 0;
  logic [2:0] pw_state = 0;
  logic [CW-1:0] lk_ctx = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_grant, rsp_avail, rsp_err, alloc_err, lk_found, lk_match;
  logic [1:0] rsp_way;
  logic [AW-1:0] rsp_victim;

  tagdir uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  bit          m_occ [S][W];
  logic [AW-1:0] m_line [S][W];
  int          m_perm [S][W];
  bit          m_lkv [S][W];
  int          m_own [S][W];
  int          m_age [S][W];

  typedef struct { bit hit; int way; bit grant; bit avail; bit err; logic [AW-1:0] vic; } exp_t;

  function automatic int setof(logic [AW-1:0] a); return int'(a[5:4]); endfunction
  function automatic logic [AW-1:0] mk(int tag, int set); return AW'((tag << 6) | (set << 4)); endfunction

  function automatic int mhit(logic [AW-1:0] a);
    int s = setof(a);
    for (int w = 0; w < W; w++) if (m_occ[s][w] && m_line[s][w] == a && m_perm[s][w] != 0) return w;
    return -1;
  endfunction
  function automatic int mfree(int s);
    for (int w = 0; w < W; w++) if (!m_occ[s][w] || m_perm[s][w] == 0) return w;
    return -1;
  endfunction
  function automatic bit mavail(logic [AW-1:0] a);
    int s = setof(a);
    for (int w = 0; w < W; w++) if (m_occ[s][w] && m_line[s][w] == a) return 1;
    return mfree(s) >= 0;
  endfunction
  function automatic int mvictim(int s);
    int v = 0;
    for (int w = 1; w < W; w++) if (m_age[s][w] > m_age[s][v]) v = w;
    return v;
  endfunction
  function automatic void mtouch(int s, int way);
    for (int w = 0; w < W; w++)
      if (w == way) m_age[s][w] = 0; else if (m_age[s][w] < W - 1) m_age[s][w]++;
  endfunction
  function automatic void mreset();
    for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) begin
      m_occ[s][w] = 0; m_line[s][w] = 0; m_perm[s][w] = 0; m_lkv[s][w] = 0; m_own[s][w] = 0; m_age[s][w] = W - 1;
    end
  endfunction

  function automatic exp_t predict(int op, logic [AW-1:0] a, int kind);
    exp_t e; int s = setof(a); int h = mhit(a); int f = mfree(s);
    e.hit = h >= 0; e.avail = mavail(a);
    e.err = (op == 1) && (e.hit || !e.avail);
    e.way = (op == 1) ? f : h;
    e.grant = (op == 0) && e.hit &&
              (m_perm[s][h] == 3 || (m_perm[s][h] == 2 && kind != 2));
    e.vic = m_line[s][mvictim(s)];
    return e;
  endfunction

  function automatic void apply(int op, logic [AW-1:0] a, bit touch);
    int s = setof(a); int h = mhit(a); int f = mfree(s);
    if (op == 0 && h >= 0) mtouch(s, h);
    if (op == 1 && h < 0 && mavail(a)) begin
      m_occ[s][f] = 1; m_line[s][f] = a; m_perm[s][f] = 1; m_lkv[s][f] = 0;
      if (touch) mtouch(s, f);
    end
    if (op == 2 && h >= 0) begin m_occ[s][h] = 0; m_perm[s][h] = 0; m_lkv[s][h] = 0; end
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", tag, act, exp); end
  endtask

  task automatic check_rsp(int op, exp_t e);
    chk(rsp_valid === 1'b1, "R11 rsp_valid", rsp_valid, 1);
    chk(rsp_hit === e.hit, "R2 hit", rsp_hit, e.hit);
    chk(rsp_avail === e.avail, "R5 avail", rsp_avail, e.avail);
    chk(rsp_grant === e.grant, "R3 grant", rsp_grant, e.grant);
    chk(rsp_err === e.err, "R10 err", rsp_err, e.err);
    if ((op != 1 && e.hit) || (op == 1 && !e.err))
      chk(int'(rsp_way) == e.way, "R6 way", rsp_way, e.way);
    if (op == 3 && !e.avail)
      chk(rsp_victim === e.vic, "R8 victim", rsp_victim, e.vic);
  endtask

  task automatic req(int op, logic [AW-1:0] a, int kind = 0, bit touch = 1);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = a; req_kind = 2'(kind); req_touch = touch;
    e = predict(op, a, kind);
    @(posedge clk); #1;
    req_valid = 0;
    check_rsp(op, e);
    apply(op, a, touch);
  endtask

  task automatic pwrite(logic [AW-1:0] a, int st);
    int s = setof(a);
    @(negedge clk);
    pw_en = 1; pw_addr = a; pw_state = 3'(st);
    @(posedge clk); #1;
    pw_en = 0;
    for (int w = 0; w < W; w++) if (m_occ[s][w] && m_line[s][w] == a) m_perm[s][w] = st;
  endtask

  task automatic lock(int op, logic [AW-1:0] a, int ctx);
    int s = setof(a); int h = mhit(a); bit em;
    @(negedge clk);
    lk_en = 1; lk_op = 2'(op); lk_addr = a; lk_ctx = CW'(ctx);
    #1;
    em = (op == 2) && h >= 0 && m_lkv[s][h] && m_own[s][h] == ctx;
    chk(lk_found === (h >= 0), "R9 found", lk_found, h >= 0);
    chk(lk_match === em, "R9 match", lk_match, em);
    @(posedge clk); #1;
    lk_en = 0;
    if (h >= 0 && op == 0) begin m_lkv[s][h] = 1; m_own[s][h] = ctx; end
    if (h >= 0 && op == 1) m_lkv[s][h] = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t ea, eb;
    void'($urandom(32'd1234));
    mreset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R12 reset state
    chk(rsp_valid === 1'b0, "R12 rsp_valid", rsp_valid, 0);
    chk(req_ready === 1'b1, "R12 req_ready", req_ready, 1);
    chk(alloc_err === 1'b0, "R12 alloc_err", alloc_err, 0);
    for (int s = 0; s < S; s++) req(0, mk(1, s), 0);

    // R6/R3 single line through states
    req(1, mk(1, 0), 0, 1);
    req(0, mk(1, 0), 0);          // invalid: hit, not granted (R3)
    pwrite(mk(1, 0), 2);          // R13 read-only
    req(0, mk(1, 0), 0);
    req(0, mk(1, 0), 1);
    req(0, mk(1, 0), 2);          // store denied, way reported
    pwrite(mk(1, 0), 3);
    req(0, mk(1, 0), 2);
    pwrite(mk(1, 0), 4);          // busy
    req(0, mk(1, 0), 0);

    // R1/R6 fill set 0, R10 overflow
    for (int t = 2; t <= 4; t++) req(1, mk(t, 0), 0, 0);
    req(3, mk(5, 0));             // R8 probe, no slot
    req(1, mk(5, 0), 0, 1);       // R10 refused
    chk(alloc_err === 1'b1, "R10 sticky", alloc_err, 1);
    req(1, mk(2, 0), 0, 1);       // R10 already present
    req(0, mk(5, 0), 0);          // unchanged: miss
    req(1, mk(5, 1), 0, 1);       // R1 other set still free
    chk(int'(rsp_way) == 0, "R1 other set way0", rsp_way, 0);
    // R4 denied access still refreshes recency
    pwrite(mk(3, 0), 2);
    req(3, mk(6, 0));
    req(0, mk(3, 0), 2);
    req(3, mk(6, 0));
    // R2 absent line misses and is reused
    pwrite(mk(2, 0), 0);
    req(0, mk(2, 0), 0);
    req(1, mk(7, 0), 0, 1);
    chk(int'(rsp_way) == 1, "R6 reuse absent way", rsp_way, 1);
    // R7 deallocate
    req(2, mk(4, 0));
    req(0, mk(4, 0), 0);
    chk(rsp_hit === 1'b0, "R7 gone", rsp_hit, 0);
    // R9 locks
    lock(0, mk(7, 0), 5);
    lock(2, mk(7, 0), 5);
    lock(2, mk(7, 0), 6);
    lock(1, mk(7, 0), 0);
    lock(2, mk(7, 0), 5);
    lock(0, mk(0, 3), 2);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_op = 0; req_addr = mk(7, 0); req_kind = 0;
    ea = predict(0, mk(7, 0), 0);
    @(posedge clk); #1;
    apply(0, mk(7, 0), 0);
    req_addr = mk(1, 0); req_kind = 2;
    eb = predict(0, mk(1, 0), 2);
    chk(req_ready === 1'b0, "R11 stalled ready", req_ready, 0);
    @(posedge clk); #1;
    check_rsp(0, ea);
    chk(req_ready === 1'b0, "R11 still stalled", req_ready, 0);
    @(negedge clk); rsp_ready = 1;
    @(posedge clk); #1;
    req_valid = 0;
    check_rsp(0, eb);
    apply(0, mk(1, 0), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      logic [AW-1:0] a = mk($urandom_range(0, 7), $urandom_range(0, 3));
      if (r < 4) req(0, a, $urandom_range(0, 2));
      else if (r < 6) req(1, a, 0, 1'($urandom_range(0, 1)));
      else if (r == 6) req(2, a);
      else if (r == 7) req(3, a);
      else if (r == 8) pwrite(a, $urandom_range(0, 4));
      else lock($urandom_range(0, 2), a, $urandom_range(0, 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule